// File: doc/BRIEF.md
# Resonance Tuning Capacitor Controller

This block holds a resonant receive tank on its tuning point by stepping a bank of binary-weighted switched capacitors. Two flags come from an envelope window check. One says the coil amplitude has fallen below the window and the other says it has risen above it. The block integrates these flags into a 7-bit tuning code. Bit i of the code closes the switch that adds 2^i unit capacitors, so the code value is the number of units connected to the tank. The units are nominally 8 pF, which gives a range of 0 to 1016 pF.

The flags arrive from analog comparators, so each one passes through a two-flop synchronizer first. The code moves by at most one step per settle period of `SETTLE_CYCLES` clocks, which gives the envelope time to respond before the next decision. A low amplitude adds capacitance and a high amplitude removes it. When the amplitude is inside the window, or when the two flags contradict each other, the code stays where it is. The code saturates at both ends of its range and never wraps.

The enable input is driven by the inverse of the end-of-charge condition. While enable is low the array is held empty, which leaves only the fixed tank capacitance. A synchronous, active-high reset also empties the array.

Top module: `tank_tuner`

## Requirements
- R1: A synchronous reset forces `tune_code` to 0 at the next rising clock edge, regardless of the other inputs.
- R2: With `amp_low`=1 and `amp_high`=0, each update adds exactly one to `tune_code`. Repeated updates can climb through code 78 (624 pF of 8 pF units) without interruption.
- R3: With `amp_low`=0 and `amp_high`=1, each update subtracts exactly one from `tune_code`.
- R4: With both flags at 0 (amplitude inside the window), an update leaves `tune_code` unchanged.
- R5: With both flags at 1 (invalid input), an update leaves `tune_code` unchanged.
- R6: An increment request at code 127 leaves the code at 127.
- R7: A decrement request at code 0 leaves the code at 0.
- R8: After enable is sampled high, updates occur only on the `SETTLE_CYCLES`-th rising edge and on every `SETTLE_CYCLES`-th edge after it. `tune_code` does not change on any other edge while enabled.
- R9: Each flag is sampled through two flip-flops. A flag level that first appears one cycle before an update edge has no effect on that update, but it is acted on at the following update.
- R10: While `en` is low, `tune_code` becomes 0 at the next rising edge and stays 0 whatever the flags do. The settle period restarts from zero when `en` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Tuning enable; low after end of charge |
| amp_low | input | 1 | Asynchronous flag: coil amplitude below the lower window edge |
| amp_high | input | 1 | Asynchronous flag: coil amplitude above the upper window edge |
| tune_code | output | CODE_W (7) | Registered capacitor switch word; bit i weighs 2^i units |

## Verification
While enabled, a change in the code is due only on edge `SETTLE_CYCLES` after enable is sampled high and on every multiple of that edge. Disable and reset each take effect one edge after they are sampled. A flag needs two edges to reach the decision logic. The bench counts edges from the point where it raises enable and changes the flags only just after an update edge. It then compares the code one half period after the edge on which the requirements place the step. Separate directed cases sample one edge before and one edge after an update. They also place a flag change one cycle before an update edge to show the synchronizer delay.

// File: rtl/tank_tune_pkg.sv
package tank_tune_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= async_in[i];
        sync_q <= meta_q;
      end
    end
    assign sync_out[i] = sync_q;
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int PERIOD = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == LAST);

  if (PERIOD > 1) begin : g_chk
    // R8: one decision per settle period, never two in a row
    assert_tick_spaced_R8: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);
  end
endmodule

// File: rtl/step_decode.sv
module step_decode
  import tank_tune_pkg::*;
(
  input  logic  below,
  input  logic  above,
  output step_e step
);
  always_comb begin
    unique case ({below, above})
      2'b10:   step = STEP_INC;
      2'b01:   step = STEP_DEC;
      default: step = STEP_HOLD;
    endcase
  end
endmodule

// File: rtl/tune_code_reg.sv
module tune_code_reg
  import tank_tune_pkg::*;
#(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  step_e            step,
  output logic [WIDTH-1:0] code
);
  localparam logic [WIDTH-1:0] CODE_MAX = {WIDTH{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      code <= '0;
    end else if (tick) begin
      case (step)
        STEP_INC: if (code != CODE_MAX) code <= code + 1'b1;
        STEP_DEC: if (code != '0)       code <= code - 1'b1;
        default:  code <= code;
      endcase
    end
  end

  assert_inc_by_one_R2: assert property (@(posedge clk) disable iff (rst)
    (en && tick && step == STEP_INC && code != CODE_MAX) |=> code == $past(code) + 1'b1);
  assert_dec_by_one_R3: assert property (@(posedge clk) disable iff (rst)
    (en && tick && step == STEP_DEC && code != '0) |=> code == $past(code) - 1'b1);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (en && tick && step == STEP_INC && code == CODE_MAX) |=> code == CODE_MAX);
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (en && tick && step == STEP_DEC && code == '0) |=> code == '0);
  assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(code));
  assert_empty_when_off_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> code == '0);
endmodule

// File: rtl/tank_tuner.sv
module tank_tuner
  import tank_tune_pkg::*;
#(
  parameter int CODE_W        = 7,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              amp_low,
  input  logic              amp_high,
  output logic [CODE_W-1:0] tune_code
);
  localparam int N_FLAGS = 2;

  logic [N_FLAGS-1:0] flags_s;
  logic               tick;
  step_e              step;

  flag_sync #(.WIDTH(N_FLAGS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({amp_high, amp_low}),
    .sync_out (flags_s)
  );

  settle_timer #(.PERIOD(SETTLE_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (en),
    .tick (tick)
  );

  step_decode u_dec (
    .below (flags_s[0]),
    .above (flags_s[1]),
    .step  (step)
  );

  tune_code_reg #(.WIDTH(CODE_W)) u_code (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .tick (tick),
    .step (step),
    .code (tune_code)
  );

  // R5: contradictory synchronized flags never move the array
  assert_conflict_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (en && tick && flags_s[0] && flags_s[1]) |=> $stable(tune_code));
  // R4: in-window amplitude never moves the array
  assert_window_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !flags_s[0] && !flags_s[1]) |=> $stable(tune_code));
  // R1: code is empty on the first edge after reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> tune_code == '0);
endmodule

// File: tb/tank_tuner_tb.sv
`timescale 1ns/1ps
module tank_tuner_tb;
  localparam int N  = 8;
  localparam int CW = 7;
  localparam int NV = 11;

  // entry: {amp_low, amp_high, updates[6:0], expected code[6:0]}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b0, 7'd2,  7'd0},    // R4 hold at start
    {1'b0, 1'b1, 7'd3,  7'd0},    // R7 floor
    {1'b1, 1'b0, 7'd5,  7'd5},    // R2 climb
    {1'b1, 1'b1, 7'd3,  7'd5},    // R5 conflict holds
    {1'b1, 1'b0, 7'd73, 7'd78},   // R2 reach 624 pF
    {1'b0, 1'b0, 7'd4,  7'd78},   // R4 window hold
    {1'b0, 1'b1, 7'd10, 7'd68},   // R3 descend
    {1'b1, 1'b0, 7'd70, 7'd127},  // R6 ceiling
    {1'b1, 1'b0, 7'd3,  7'd127},  // R6 stays at ceiling
    {1'b1, 1'b1, 7'd2,  7'd127},  // R5 conflict at top
    {1'b0, 1'b1, 7'd1,  7'd126}   // R3 single step down
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          amp_low = 1'b0;
  logic          amp_high = 1'b0;
  logic [CW-1:0] tune_code;
  int            n_checks = 0;
  int            n_errors = 0;

  always #10 clk = ~clk;

  tank_tuner #(.CODE_W(CW), .SETTLE_CYCLES(N)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .amp_low   (amp_low),
    .amp_high  (amp_high),
    .tune_code (tune_code)
  );

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: tune_code=%0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    amp_low = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", tune_code, 7'd0);
    rst = 1'b0;

    // table walk: enable and the first flags change together; updates fall on every N-th edge
    for (int v = 0; v < NV; v++) begin
      amp_low  = VEC[v][15];
      amp_high = VEC[v][14];
      en       = 1'b1;
      repeat (int'(VEC[v][13:7]) * N) @(posedge clk);
      @(negedge clk);
      check($sformatf("vector %0d (R2..R7)", v), tune_code, VEC[v][6:0]);
    end

    // R8: nothing moves one edge before the update, one step on the update edge
    amp_low = 1'b1; amp_high = 1'b0;
    repeat (N - 1) @(posedge clk);
    @(negedge clk);
    check("R8 before update edge", tune_code, 7'd126);
    @(posedge clk);
    @(negedge clk);
    check("R8 on update edge", tune_code, 7'd127);

    // R10: disable empties on the next edge and flags are ignored
    en = 1'b0; amp_low = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10 cleared after disable", tune_code, 7'd0);
    amp_low = 1'b1;
    repeat (3 * N) @(posedge clk);
    @(negedge clk);
    check("R10 flags ignored while off", tune_code, 7'd0);

    // R9: a flag raised one cycle before the update edge misses that update
    amp_low = 1'b0;
    en = 1'b1;
    repeat (N - 2) @(posedge clk);
    @(negedge clk);
    amp_low = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 late flag not used", tune_code, 7'd0);
    repeat (N) @(posedge clk);
    @(negedge clk);
    check("R9 flag used next update", tune_code, 7'd1);
    repeat (N) @(posedge clk);
    @(negedge clk);
    check("R2 second step after re-enable", tune_code, 7'd2);

    // R1: reset in the middle of a run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset mid run", tune_code, 7'd0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule